// File: doc/BRIEF.md
# Dynamic Priority Arbiter with Maximum Tree

This block arbitrates among a set of requesters (eight by default) for one shared resource. Each requester presents a request line and a small unsigned priority value (4 bits by default). When the arbiter is idle and any request is high, it takes a snapshot of all request lines and priority values into a lock register. Evaluation then uses only that snapshot.

A binary tree of maximum-selection cells reduces the snapshot to one winner. Each cell carries a valid flag, a channel index and a priority. A cell compares data only when both of its children are valid. If one child is valid, the cell passes it upward unchanged. Each tree step costs one clock cycle only when it contains a real comparison. Steps that need no comparison are crossed within the same cycle. As a result, a lone request is granted in one cycle, and a full contest takes one cycle per tree level.

The winner receives a one-hot grant and a one-cycle done pulse. The grant is held until the winning request drops. Other requests that are high during the grant simply wait and are taken at the next snapshot.

Top module: `dyn_prio_arbiter`

## Requirements
- R1: While reset is asserted and after its release with no request, `grant` is all zeros and `done` is 0.
- R2: A snapshot is taken at a rising clock edge when the arbiter is idle and at least one `req` bit is high. Changes to `req` or `prio` after that edge do not affect the outcome of this arbitration.
- R3: The grant goes to the snapshotted channel with the largest priority value. Channel i's priority is the unsigned field `prio[i*PW +: PW]`.
- R4: When several snapshotted channels share the largest priority value, the channel with the lowest index wins.
- R5: `grant` is one-hot. Bit i set means channel i is granted.
- R6: `grant` and `done` appear C rising edges after the snapshot edge. C is the larger of 1 and the number of tree levels that contain at least one pair with both members valid. Level 0 pairs channels 2j and 2j+1. Each later level pairs the results of the level below in the same way.
- R7: `done` is high for exactly one cycle, in the cycle where `grant` first becomes non-zero. `done` never rises without a snapshot.
- R8: The grant stays unchanged while the granted channel's `req` bit stays high. Requests that rise in the meantime do not alter it.
- R9: At the first rising edge where the granted channel's `req` bit is low, `grant` returns to zero. A new snapshot may be taken at the very next edge.
- R10: Requests that were held high during a grant are arbitrated at the next snapshot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Request line per channel |
| prio | input | N*PW | Packed priority values, channel i in bits [i*PW +: PW] |
| grant | output | N | One-hot grant |
| done | output | 1 | One-cycle pulse when a grant is issued |

## Verification
The bench builds the arbiter with its default eight channels and 4-bit priorities. This gives a three-level tree, so every latency from one to three cycles can be produced by choosing which channels request together. The 4-bit field lets the bench exercise the priority extremes 0 and 15, full ties and partial ties. The bench also covers:
- changing priorities after the snapshot;
- requests that pile up behind a held grant;
- back-to-back arbitrations that begin in the cycle after a release.

// File: rtl/dyn_prio_arbiter.sv
module dyn_prio_arbiter #(
  parameter int N  = 8,
  parameter int PW = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    req,
  input  logic [N*PW-1:0] prio,
  output logic [N-1:0]    grant,
  output logic            done
);
  localparam int L  = $clog2(N);
  localparam int IW = (L > 0) ? L : 1;
  localparam int LW = $clog2(L + 1) > 0 ? $clog2(L + 1) : 1;

  typedef struct packed {
    logic          v;
    logic [IW-1:0] idx;
    logic [PW-1:0] p;
  } node_t;

  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_GRANT} state_t;

  state_t        state;
  node_t         cur [N];
  logic [LW-1:0] lvl;
  node_t         tr  [L+1][N];
  logic [L-1:0]  need;
  logic [LW-1:0] adv;

  always_comb begin
    node_t a, b;
    for (int j = 0; j < N; j++) tr[0][j] = cur[j];
    for (int i = 0; i < L; i++) begin
      need[i] = 1'b0;
      for (int j = 0; j < N; j++) tr[i+1][j] = '0;
      for (int j = 0; j < N/2; j++) begin
        a = tr[i][2*j];
        b = tr[i][2*j+1];
        if (a.v && b.v) begin
          need[i]     = 1'b1;
          tr[i+1][j]  = (b.p > a.p) ? b : a;
        end else begin
          tr[i+1][j]  = a.v ? a : b;
        end
      end
    end
  end

  always_comb begin
    logic seen, stop;
    seen = 1'b0;
    stop = 1'b0;
    adv  = '0;
    for (int i = 0; i < L; i++) begin
      if (!stop && (i < L - int'(lvl))) begin
        if (need[i] && seen) stop = 1'b1;
        else begin
          seen = seen | need[i];
          adv  = LW'(i + 1);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      lvl   <= '0;
      grant <= '0;
      done  <= 1'b0;
      for (int j = 0; j < N; j++) cur[j] <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (|req) begin
          for (int j = 0; j < N; j++) begin
            cur[j].v   <= req[j];
            cur[j].idx <= IW'(j);
            cur[j].p   <= prio[j*PW +: PW];
          end
          lvl   <= '0;
          state <= S_EVAL;
        end
        S_EVAL: begin
          for (int j = 0; j < N; j++) cur[j] <= tr[adv][j];
          lvl <= lvl + adv;
          if (int'(lvl) + int'(adv) >= L) begin
            grant <= N'(1) << tr[adv][0].idx;
            done  <= 1'b1;
            state <= S_GRANT;
          end
        end
        S_GRANT: if ((grant & req) == '0) begin
          grant <= '0;
          lvl   <= '0;
          for (int j = 0; j < N; j++) cur[j] <= '0;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dyn_prio_arbiter_chk.sv
module dyn_prio_arbiter_chk #(
  parameter int N = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic [N-1:0] grant,
  input logic         done
);
  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant)); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_DONE_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (grant != '0 && $past(grant) == '0)); // R7
  AST_RISE_HAS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && $past(grant) == '0) |-> done); // R7
  AST_GRANT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (grant & req) != '0) |=> $stable(grant)); // R8
  AST_GRANT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    (grant != '0 && (grant & req) == '0) |=> grant == '0); // R9
endmodule

bind dyn_prio_arbiter dyn_prio_arbiter_chk #(.N(N)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .grant(grant), .done(done)
);

// File: tb/test_dyn_prio_arbiter.sv
module test_dyn_prio_arbiter;
  localparam int N  = 8;
  localparam int PW = 4;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [N-1:0]    req = '0;
  logic [N*PW-1:0] prio = '0;
  logic [N-1:0]    grant;
  logic            done;

  dyn_prio_arbiter #(.N(N), .PW(PW)) i_dyn_prio_arbiter (
    .clk(clk), .rst_n(rst_n), .req(req), .prio(prio), .grant(grant), .done(done)
  );

  always #10 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int errors = 0;
  logic [N-1:0] q_grant[$];
  int           q_cyc[$];
  string        q_tag[$];
  logic         done_d = 1'b0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_win(input logic [N-1:0] r, input logic [N*PW-1:0] p);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (r[i] && (best < 0 || p[i*PW +: PW] > p[best*PW +: PW])) best = i;
    return (best < 0) ? '0 : (N'(1) << best);
  endfunction

  function automatic int exp_lat(input logic [N-1:0] r);
    logic [N-1:0] v = r;
    int n = 0;
    for (int w = N; w > 1; w = w / 2) begin
      logic [N-1:0] nv = '0;
      bit hit = 0;
      for (int j = 0; j < w / 2; j++) begin
        if (v[2*j] && v[2*j+1]) hit = 1;
        nv[j] = v[2*j] | v[2*j+1];
      end
      if (hit) n++;
      v = nv;
    end
    return (n < 1) ? 1 : n;
  endfunction

  always @(negedge clk) begin
    logic [N-1:0] g;
    int c;
    string t;
    if (rst_n) begin
      if (done) begin
        if (q_grant.size() == 0) chk(0, "R7", "done without snapshot", 1, 0);
        else begin
          g = q_grant.pop_front();
          c = q_cyc.pop_front();
          t = q_tag.pop_front();
          chk(grant == g, t, "granted channel", grant, g);
          chk(cyc == c, "R6", "grant cycle", cyc, c);
        end
      end
      if (done && done_d) chk(0, "R7", "done longer than one cycle", 1, 0);
      done_d <= done;
    end
  end

  task automatic arb(input logic [N-1:0] r, input logic [N*PW-1:0] p, input string tag);
    req  = r;
    prio = p;
    q_grant.push_back(exp_win(r, p));
    q_cyc.push_back(cyc + 1 + exp_lat(r));
    q_tag.push_back(tag);
  endtask

  task automatic wait_done();
    wait (q_grant.size() == 0);
    @(negedge clk);
  endtask

  task automatic release_all();
    req = '0;
    @(negedge clk);
    chk(grant == '0, "R9", "grant after release", grant, 0);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(grant == '0, "R1", "grant in reset", grant, 0);
    chk(done == 1'b0, "R1", "done in reset", done, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(grant == '0 && done == 1'b0, "R1", "idle after reset", {grant, done}, 0);

    // R3 R6: lone request, one-cycle grant
    arb(8'h08, 32'h0000_2000, "R3");
    wait_done();
    chk(grant == 8'h08, "R5", "one-hot grant held", grant, 8'h08);
    release_all();

    // R3: all eight requesters, distinct priorities, channel 2 holds E
    arb(8'hFF, 32'h3A5C_1E27, "R3");
    wait_done();
    release_all();

    // R4: full tie goes to channel 0
    arb(8'hFF, 32'h6666_6666, "R4");
    wait_done();
    release_all();

    // R4: partial tie among channels 2, 5, 7
    arb(8'hA4, 32'h9090_0900, "R4");
    wait_done();
    release_all();

    // R3 R6: far channels meet only at the root
    arb(8'h81, 32'h4000_0003, "R3");
    wait_done();
    release_all();

    // R2: priorities and requests change after the snapshot
    arb(8'h0E, 32'h0000_2850, "R2");
    @(negedge clk);
    prio = '1;
    req  = 8'h0F;
    wait_done();
    req = '0;
    @(negedge clk);
    req = '0;
    chk(grant == '0, "R9", "grant after release", grant, 0);

    // R8 R10: requests pile up behind a held grant
    arb(8'h10, 32'h0900_0030, "R8");
    wait_done();
    req = 8'h52;
    @(negedge clk);
    chk(grant == 8'h10, "R8", "grant unchanged by new requests", grant, 8'h10);
    @(negedge clk);
    chk(done == 1'b0, "R8", "no new done while held", done, 0);
    req = 8'h42;
    @(negedge clk);
    chk(grant == '0, "R9", "grant cleared on drop", grant, 0);
    arb(8'h42, 32'h0900_0030, "R10");
    wait_done();
    release_all();

    // R3: priority extremes 0 and F
    arb(8'h43, 32'h0F00_00E0, "R3");
    wait_done();
    release_all();

    // R4: zero priorities tie to the lower index
    arb(8'h28, 32'h0000_0000, "R4");
    wait_done();
    release_all();

    repeat (4) @(negedge clk);
    chk(grant == '0 && done == 1'b0, "R7", "quiet without requests", {grant, done}, 0);
    chk(q_grant.size() == 0, "R6", "outstanding expectations", q_grant.size(), 0);
    finish_run();
  end
endmodule